// File: doc/BRIEF.md
# Length-Counted Two-Wire Host Transaction Sequencer

This block drives a byte-level two-wire bus engine on behalf of software for one host transaction at a time. A single configuration write supplies the 7-bit target address, the transfer direction, an 8-bit byte count and a length-enable bit. The sequencer then issues commands to the engine. It sends start-plus-address first, then the data bytes. When the count is enabled it closes the transfer itself: the final read byte gets a not-acknowledge and a stop follows. Write data is pulled from a data path through a valid/ready handshake, and read data is pushed out through another one.

With length-enable clear, the block stops after the address phase. It then performs single-byte operations and the stop only when software asks for them. Three sticky flags record problems: an early client NACK during a counted write (length error), an address NACK, and an error interrupt. Each flag is cleared by a write-one strobe.

Engine command codes on `eng_cmd_o` are 0 = start plus address, 1 = write byte, 2 = read byte with ACK, 3 = read byte with NACK, and 4 = stop. For a start, `eng_data_o` carries the address in bits 7:1 and the direction in bit 0 (1 = read). For a write, it carries the byte to send. Software commands on `sw_cmd_i` are 0 = write one byte, 1 = read with ACK, 2 = read with NACK, and 3 = stop. The flag clear vector `st_clr_i` uses bit 0 for length error, bit 1 for address NACK and bit 2 for the error interrupt.

Top module: `len_txn_seq`

## Requirements
- R1: After reset, `busy_o`, all three flags, `eng_cmd_valid_o`, `tx_ready_o` and `rx_valid_o` are 0.
- R2: A configuration write while idle raises `busy_o` in the next cycle. The first engine command is then code 0, with `eng_data_o` = {address, direction}.
- R3: With length-enable set and length L (0 to 255), exactly L data-byte commands follow an acknowledged address, and then a stop (code 4). With L = 0 the stop follows the address directly.
- R4: On a counted read, the first L-1 byte commands are code 2 and the last is code 3. Each engine response byte is offered on `rx_data_o`, in order, and held until `rx_ready_i`.
- R5: On a counted write, each byte is taken from `tx_data_i` on a `tx_valid_i`/`tx_ready_o` handshake. The bytes are sent in order as code 1 commands carrying that byte.
- R6: On a counted write, a client NACK on any byte before the last causes the next command to be a stop, and sets the length-error and error-interrupt flags.
- R7: On a counted write, a client NACK on the last byte completes the transfer normally, with a stop and no length error.
- R8: An address NACK is followed directly by a stop. It sets the address-NACK and error-interrupt flags, sends no data commands, and leaves length error clear.
- R9: With length-enable clear, no command follows the address until a software command arrives. Each software command produces its one engine command. No automatic stop occurs, a write NACK sets no length error, and software commands are ignored while idle.
- R10: `busy_o` stays 1 from the configuration write until the engine responds to the stop. Configuration writes made while busy have no effect.
- R11: A 1 in `st_clr_i` clears the matching flag and leaves the other flags unchanged.
- R12: While `eng_cmd_valid_o` is 1 and `eng_cmd_ready_i` is 0, the command and its data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Target address |
| cfg_rd_i | input | 1 | Direction, 1 = read |
| cfg_len_i | input | 8 | Data byte count |
| cfg_lenen_i | input | 1 | Use the count and automatic ending |
| sw_cmd_valid_i | input | 1 | Software command strobe (manual mode) |
| sw_cmd_i | input | 2 | Software command code |
| st_clr_i | input | 3 | Write-one flag clear |
| eng_cmd_valid_o | output | 1 | Engine command valid |
| eng_cmd_o | output | 3 | Engine command code |
| eng_data_o | output | 8 | Address byte or write byte |
| eng_cmd_ready_i | input | 1 | Engine accepts command |
| eng_rsp_valid_i | input | 1 | Engine finished the accepted command |
| eng_rsp_nack_i | input | 1 | Client answered NACK |
| eng_rsp_data_i | input | 8 | Byte read from the client |
| tx_valid_i | input | 1 | Write byte available |
| tx_data_i | input | 8 | Write byte |
| tx_ready_o | output | 1 | Sequencer takes write byte |
| rx_valid_o | output | 1 | Read byte available |
| rx_data_o | output | 8 | Read byte |
| rx_ready_i | input | 1 | Sink takes read byte |
| busy_o | output | 1 | Transaction in progress |
| len_err_o | output | 1 | Length-error flag |
| addr_nack_o | output | 1 | Address-NACK flag |
| err_irq_o | output | 1 | Error interrupt flag |

## Verification
The assertions assume the engine raises `eng_rsp_valid_i` for exactly one cycle for each accepted command, and only after it has accepted that command. They also assume `eng_rsp_nack_i` is meaningful only together with that response. The bench engine model enforces this: it counts accepted commands against issued responses and answers each one exactly once, one half-cycle later. Its ready line is either held high or toggled every cycle. Software strobes are sent only after the sequencer has had time to settle in its waiting state, so none of them lands during a handshake.

// File: rtl/len_seq_pkg.sv
package len_seq_pkg;
  typedef enum logic [2:0] {
    CMD_START   = 3'd0,
    CMD_WRITE   = 3'd1,
    CMD_RD_ACK  = 3'd2,
    CMD_RD_NACK = 3'd3,
    CMD_STOP    = 3'd4
  } eng_cmd_e;

  typedef enum logic [1:0] {
    SW_WRITE   = 2'd0,
    SW_RD_ACK  = 2'd1,
    SW_RD_NACK = 2'd2,
    SW_STOP    = 2'd3
  } sw_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_W, S_FETCH, S_WR, S_WR_W,
    S_RD, S_RD_W, S_PUSH, S_MAN, S_STOP, S_STOP_W
  } seq_state_e;

  localparam int FLAG_N   = 3;
  localparam int FLG_LEN  = 0;
  localparam int FLG_ADDR = 1;
  localparam int FLG_IRQ  = 2;
endpackage

// File: rtl/len_seq_count.sv
module len_seq_count #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             zero_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == LEN_W'(1));

  // R3
  cnt_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/len_seq_flags.sv
module len_seq_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;  // set wins over clear
      else if (clr_i[i]) flag_q <= 1'b0;
    end
    assign flags_o[i] = flag_q;

    // R11
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] && !set_i[i] |=> !flags_o[i]);
    // R11
    w1c_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i[i] && !set_i[i] |=> $stable(flags_o[i]));
  end
endmodule

// File: rtl/len_seq_ctrl.sv
module len_seq_ctrl
  import len_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-2:0] cfg_addr_i,
  input  logic              cfg_rd_i,
  input  logic              cfg_lenen_i,
  input  logic              sw_cmd_valid_i,
  input  logic [1:0]        sw_cmd_i,
  output logic              eng_cmd_valid_o,
  output logic [2:0]        eng_cmd_o,
  output logic [DATA_W-1:0] eng_data_o,
  input  logic              eng_cmd_ready_i,
  input  logic              eng_rsp_valid_i,
  input  logic              eng_rsp_nack_i,
  input  logic [DATA_W-1:0] eng_rsp_data_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rx_ready_i,
  output logic              cnt_load_o,
  output logic              cnt_dec_o,
  input  logic              cnt_last_i,
  input  logic              cnt_zero_i,
  output logic              set_len_err_o,
  output logic              set_addr_nack_o,
  output logic              busy_o
);
  seq_state_e        state_q, state_d;
  logic [DATA_W-2:0] addr_q;
  logic              rd_q, auto_q, man_nack_q, man_nack_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              take_cfg;

  assign take_cfg = (state_q == S_IDLE) && cfg_we_i;

  always_comb begin
    state_d         = state_q;
    byte_d          = byte_q;
    man_nack_d      = man_nack_q;
    eng_cmd_valid_o = 1'b0;
    eng_cmd_o       = CMD_STOP;
    eng_data_o      = byte_q;
    tx_ready_o      = 1'b0;
    rx_valid_o      = 1'b0;
    cnt_dec_o       = 1'b0;
    set_len_err_o   = 1'b0;
    set_addr_nack_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (cfg_we_i) state_d = S_ADDR;
      S_ADDR: begin
        eng_cmd_valid_o = 1'b1;
        eng_cmd_o       = CMD_START;
        eng_data_o      = {addr_q, rd_q};
        if (eng_cmd_ready_i) state_d = S_ADDR_W;
      end
      S_ADDR_W: if (eng_rsp_valid_i) begin
        if (eng_rsp_nack_i) begin
          set_addr_nack_o = 1'b1;
          state_d         = S_STOP;
        end else if (!auto_q)  state_d = S_MAN;
        else if (cnt_zero_i)   state_d = S_STOP;
        else if (rd_q)         state_d = S_RD;
        else                   state_d = S_FETCH;
      end
      S_FETCH: begin
        tx_ready_o = 1'b1;
        if (tx_valid_i) begin
          byte_d  = tx_data_i;
          state_d = S_WR;
        end
      end
      S_WR: begin
        eng_cmd_valid_o = 1'b1;
        eng_cmd_o       = CMD_WRITE;
        if (eng_cmd_ready_i) state_d = S_WR_W;
      end
      S_WR_W: if (eng_rsp_valid_i) begin
        if (!auto_q) state_d = S_MAN;
        else begin
          cnt_dec_o = 1'b1;
          if (eng_rsp_nack_i) begin
            set_len_err_o = !cnt_last_i;  // NACK on the final byte is normal
            state_d       = S_STOP;
          end else state_d = cnt_last_i ? S_STOP : S_FETCH;
        end
      end
      S_RD: begin
        eng_cmd_valid_o = 1'b1;
        if (auto_q) eng_cmd_o = cnt_last_i ? CMD_RD_NACK : CMD_RD_ACK;
        else        eng_cmd_o = man_nack_q ? CMD_RD_NACK : CMD_RD_ACK;
        if (eng_cmd_ready_i) state_d = S_RD_W;
      end
      S_RD_W: if (eng_rsp_valid_i) begin
        byte_d  = eng_rsp_data_i;
        state_d = S_PUSH;
      end
      S_PUSH: begin
        rx_valid_o = 1'b1;
        if (rx_ready_i) begin
          if (!auto_q) state_d = S_MAN;
          else begin
            cnt_dec_o = 1'b1;
            state_d   = cnt_last_i ? S_STOP : S_RD;
          end
        end
      end
      S_MAN: if (sw_cmd_valid_i) begin
        unique case (sw_cmd_e'(sw_cmd_i))
          SW_WRITE:   state_d = S_FETCH;
          SW_RD_ACK:  begin man_nack_d = 1'b0; state_d = S_RD; end
          SW_RD_NACK: begin man_nack_d = 1'b1; state_d = S_RD; end
          SW_STOP:    state_d = S_STOP;
          default:    state_d = S_MAN;
        endcase
      end
      S_STOP: begin
        eng_cmd_valid_o = 1'b1;
        eng_cmd_o       = CMD_STOP;
        if (eng_cmd_ready_i) state_d = S_STOP_W;
      end
      S_STOP_W: if (eng_rsp_valid_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      rd_q       <= 1'b0;
      auto_q     <= 1'b0;
      man_nack_q <= 1'b0;
      byte_q     <= '0;
    end else begin
      state_q    <= state_d;
      byte_q     <= byte_d;
      man_nack_q <= man_nack_d;
      if (take_cfg) begin
        addr_q <= cfg_addr_i;
        rd_q   <= cfg_rd_i;
        auto_q <= cfg_lenen_i;
      end
    end
  end

  assign cnt_load_o = take_cfg;
  assign rx_data_o  = byte_q;
  assign busy_o     = (state_q != S_IDLE);

  // R12
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_cmd_valid_o && !eng_cmd_ready_i |=>
      eng_cmd_valid_o && $stable(eng_cmd_o) && $stable(eng_data_o));
  // R4
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));
  // R6
  len_err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_len_err_o |=> eng_cmd_valid_o && eng_cmd_o == CMD_STOP);
  // R8
  addr_nack_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_addr_nack_o |=> eng_cmd_valid_o && eng_cmd_o == CMD_STOP);
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cfg_we_i |=> $stable(addr_q) && $stable(rd_q) && $stable(auto_q));
  // R10
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(eng_rsp_valid_i));
endmodule

// File: rtl/len_txn_seq.sv
module len_txn_seq
  import len_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-2:0] cfg_addr_i,
  input  logic              cfg_rd_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              cfg_lenen_i,
  input  logic              sw_cmd_valid_i,
  input  logic [1:0]        sw_cmd_i,
  input  logic [2:0]        st_clr_i,
  output logic              eng_cmd_valid_o,
  output logic [2:0]        eng_cmd_o,
  output logic [DATA_W-1:0] eng_data_o,
  input  logic              eng_cmd_ready_i,
  input  logic              eng_rsp_valid_i,
  input  logic              eng_rsp_nack_i,
  input  logic [DATA_W-1:0] eng_rsp_data_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rx_ready_i,
  output logic              busy_o,
  output logic              len_err_o,
  output logic              addr_nack_o,
  output logic              err_irq_o
);
  logic cnt_load, cnt_dec, cnt_last, cnt_zero;
  logic set_len_err, set_addr_nack;
  logic [FLAG_N-1:0] flag_set, flags;
  logic [LEN_W-1:0]  load_val;

  assign load_val = cfg_lenen_i ? cfg_len_i : '0;

  len_seq_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_rd_i, .cfg_lenen_i,
    .sw_cmd_valid_i, .sw_cmd_i,
    .eng_cmd_valid_o, .eng_cmd_o, .eng_data_o, .eng_cmd_ready_i,
    .eng_rsp_valid_i, .eng_rsp_nack_i, .eng_rsp_data_i,
    .tx_valid_i, .tx_data_i, .tx_ready_o,
    .rx_valid_o, .rx_data_o, .rx_ready_i,
    .cnt_load_o(cnt_load), .cnt_dec_o(cnt_dec),
    .cnt_last_i(cnt_last), .cnt_zero_i(cnt_zero),
    .set_len_err_o(set_len_err), .set_addr_nack_o(set_addr_nack),
    .busy_o
  );

  len_seq_count #(.LEN_W(LEN_W)) count_i (
    .clk_i, .rst_ni, .load_i(cnt_load), .load_val_i(load_val),
    .dec_i(cnt_dec), .last_o(cnt_last), .zero_o(cnt_zero)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_LEN]  = set_len_err;
    flag_set[FLG_ADDR] = set_addr_nack;
    flag_set[FLG_IRQ]  = set_len_err | set_addr_nack;
  end

  len_seq_flags #(.N(FLAG_N)) flags_i (
    .clk_i, .rst_ni, .set_i(flag_set), .clr_i(st_clr_i), .flags_o(flags)
  );

  assign len_err_o   = flags[FLG_LEN];
  assign addr_nack_o = flags[FLG_ADDR];
  assign err_irq_o   = flags[FLG_IRQ];
endmodule

// File: tb/len_txn_seq_tb_top.sv
`timescale 1ns/1ps
module len_txn_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cfg_we = 0, cfg_rd = 0, cfg_lenen = 0;
  logic [6:0] cfg_addr = 0;
  logic [7:0] cfg_len = 0;
  logic       sw_v = 0;
  logic [1:0] sw_c = 0;
  logic [2:0] st_clr = 0;
  logic       cmd_v, cmd_rdy = 1'b1, rsp_v = 0, rsp_nack = 0;
  logic [2:0] cmd;
  logic [7:0] cmd_d, rsp_d = 0, tx_d, rx_d;
  logic       tx_rdy, rx_v, busy, len_err, addr_nack, err_irq;

  len_txn_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_rd_i(cfg_rd), .cfg_len_i(cfg_len), .cfg_lenen_i(cfg_lenen),
    .sw_cmd_valid_i(sw_v), .sw_cmd_i(sw_c), .st_clr_i(st_clr),
    .eng_cmd_valid_o(cmd_v), .eng_cmd_o(cmd), .eng_data_o(cmd_d),
    .eng_cmd_ready_i(cmd_rdy), .eng_rsp_valid_i(rsp_v),
    .eng_rsp_nack_i(rsp_nack), .eng_rsp_data_i(rsp_d),
    .tx_valid_i(1'b1), .tx_data_i(tx_d), .tx_ready_o(tx_rdy),
    .rx_valid_o(rx_v), .rx_data_o(rx_d), .rx_ready_i(1'b1),
    .busy_o(busy), .len_err_o(len_err), .addr_nack_o(addr_nack),
    .err_irq_o(err_irq)
  );

  int n_pass = 0, n_tot = 0;
  bit done = 0;
  int cyc = 0, n_log = 0, fire_cnt = 0, rsp_cnt = 0, tx_cnt = 0, rx_n = 0;
  int wr_cnt = 0, wr_base = 0, pend_widx = 0;
  logic [2:0] pend_cmd = 0;
  logic [7:0] pend_data = 0;
  logic [2:0] log_cmd [0:4095];
  logic [7:0] log_dat [0:4095];
  logic [7:0] rx_log  [0:4095];
  bit anack_cfg = 0, stall_cfg = 0;
  int nack_idx_cfg = -1;

  assign tx_d = 8'h30 + tx_cnt[7:0];

  // monitor and engine acceptance
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cmd_v && cmd_rdy) begin
      log_cmd[n_log] <= cmd;
      log_dat[n_log] <= cmd_d;
      n_log     <= n_log + 1;
      fire_cnt  <= fire_cnt + 1;
      pend_cmd  <= cmd;
      pend_widx <= wr_cnt - wr_base;
      pend_data <= 8'h5A + n_log[7:0];
      if (cmd == 3'd1) wr_cnt <= wr_cnt + 1;
    end
    if (tx_rdy) tx_cnt <= tx_cnt + 1;
    if (rx_v) begin
      rx_log[rx_n] <= rx_d;
      rx_n <= rx_n + 1;
    end
  end

  // engine response, one per accepted command
  always @(negedge clk) begin
    rsp_v    <= 1'b0;
    rsp_nack <= 1'b0;
    cmd_rdy  <= stall_cfg ? cyc[0] : 1'b1;
    if (fire_cnt != rsp_cnt) begin
      rsp_v    <= 1'b1;
      rsp_nack <= (pend_cmd == 3'd0) ? anack_cfg :
                  (pend_cmd == 3'd1) ? (pend_widx == nack_idx_cfg) : 1'b0;
      rsp_d    <= pend_data;
      rsp_cnt  <= rsp_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
  endtask

  task automatic cfg_write(input logic [6:0] a, input bit rd, input int len,
                           input bit en);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_rd = rd; cfg_len = len[7:0]; cfg_lenen = en;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic sw_send(input logic [1:0] c);
    @(negedge clk);
    sw_v = 1; sw_c = c;
    @(negedge clk);
    sw_v = 0;
    repeat (30) @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (busy && k < 3000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    chk(!busy, req, "busy drops after stop response", busy, 0);
  endtask

  task automatic clear_all();
    @(negedge clk); st_clr = 3'b111;
    @(negedge clk); st_clr = 3'b000;
    @(negedge clk);
    chk({len_err, addr_nack, err_irq} == 3'b000, "R11", "flags cleared",
        {len_err, addr_nack, err_irq}, 0);
  endtask

  task automatic run_auto(input bit rd, input int len, input int k,
                          input bit an);
    int n0, t0, r0, m, nb;
    bit ok;
    int exp_c [0:300];
    int exp_d [0:300];
    logic [6:0] a;
    bit e_len;
    a = 7'(7'h11 + len * 5 + k + (rd ? 7'h40 : 0));
    @(negedge clk);
    anack_cfg = an; nack_idx_cfg = k; wr_base = wr_cnt;
    n0 = n_log; t0 = tx_cnt; r0 = rx_n;
    cfg_write(a, rd, len, 1'b1);
    chk(busy, "R2", "busy after config write", busy, 1);
    wait_idle("R10");
    m = 0;
    exp_c[m] = 0; exp_d[m] = {a, rd}; m++;
    nb = 0;
    if (!an) begin
      if (rd) begin
        for (int j = 0; j < len; j++) begin
          exp_c[m] = (j == len - 1) ? 3 : 2; exp_d[m] = -1; m++;
        end
      end else begin
        nb = (k >= 0 && k < len) ? k + 1 : len;
        for (int j = 0; j < nb; j++) begin
          exp_c[m] = 1; exp_d[m] = (8'h30 + t0 + j) & 255; m++;
        end
      end
    end
    exp_c[m] = 4; exp_d[m] = -1; m++;
    chk(n_log - n0 == m, an ? "R8" : "R3", "command count", n_log - n0, m);
    ok = 1;
    for (int i = 0; i < m && i < n_log - n0; i++) begin
      if (int'(log_cmd[n0 + i]) != exp_c[i]) ok = 0;
      if (exp_d[i] >= 0 && int'(log_dat[n0 + i]) != exp_d[i]) ok = 0;
    end
    chk(ok, rd ? "R4" : "R5", "command sequence and data", ok, 1);
    e_len = !rd && !an && k >= 0 && k < len - 1;
    chk(len_err == e_len, (k == len - 1) ? "R7" : "R6", "length error flag",
        len_err, e_len);
    chk(addr_nack == an && err_irq == (e_len | an), "R8", "addr nack / irq",
        {addr_nack, err_irq}, {an, e_len | an});
    if (rd && !an) begin
      ok = (rx_n - r0 == len);
      for (int j = 0; j < len && ok; j++)
        if (int'(rx_log[r0 + j]) != ((8'h5A + n0 + 1 + j) & 255)) ok = 0;
      chk(ok, "R4", "read bytes delivered in order", rx_n - r0, len);
    end
    if (e_len || an) clear_all();
  endtask

  initial begin
    int n0, t0, r0;
    repeat (3) @(negedge clk);
    chk(!busy && !len_err && !addr_nack && !err_irq && !cmd_v && !tx_rdy && !rx_v,
        "R1", "reset state", {busy, len_err, addr_nack, err_irq, cmd_v}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !cmd_v, "R1", "idle after reset release", busy, 0);

    // sweep counted transactions
    for (int st = 0; st < 2; st++) begin
      stall_cfg = st[0];
      for (int rd = 0; rd < 2; rd++)
        for (int len = 0; len < 7; len++) begin
          if (rd == 1) run_auto(1'b1, len, -1, 1'b0);
          else for (int k = -1; k < len; k++) run_auto(1'b0, len, k, 1'b0);
        end
      run_auto(1'b0, 3, -1, 1'b1);
      run_auto(1'b1, 3, -1, 1'b1);
    end
    stall_cfg = 0;
    run_auto(1'b1, 255, -1, 1'b0);

    // R11: selective clear
    run_auto(1'b0, 4, 1, 1'b0);
    anack_cfg = 0; nack_idx_cfg = 0; wr_base = wr_cnt;
    cfg_write(7'h22, 1'b0, 5, 1'b1);
    wait_idle("R6");
    @(negedge clk); st_clr = 3'b001;
    @(negedge clk); st_clr = 3'b000;
    @(negedge clk);
    chk(!len_err && err_irq, "R11", "clear only length error",
        {len_err, err_irq}, 1);
    @(negedge clk); st_clr = 3'b100;
    @(negedge clk); st_clr = 3'b000;
    @(negedge clk);
    chk(!err_irq, "R11", "clear irq", err_irq, 0);

    // R10: config write while busy ignored
    stall_cfg = 1; nack_idx_cfg = -1; anack_cfg = 0; wr_base = wr_cnt;
    n0 = n_log;
    cfg_write(7'h2B, 1'b0, 3, 1'b1);
    cfg_write(7'h55, 1'b1, 1, 1'b1);
    wait_idle("R10");
    repeat (20) @(negedge clk);
    chk(n_log - n0 == 5, "R10", "busy write ignored: count", n_log - n0, 5);
    chk(log_dat[n0] == {7'h2B, 1'b0} && log_cmd[n0 + 4] == 3'd4, "R10",
        "busy write ignored: address", log_dat[n0], {7'h2B, 1'b0});
    stall_cfg = 0;

    // R9: manual mode
    n0 = n_log;
    sw_send(2'd3);
    chk(n_log == n0 && !busy, "R9", "sw command while idle ignored", n_log - n0, 0);
    nack_idx_cfg = 0; wr_base = wr_cnt; t0 = tx_cnt; r0 = rx_n;
    cfg_write(7'h3C, 1'b0, 5, 1'b0);
    repeat (30) @(negedge clk);
    chk(n_log - n0 == 1 && busy, "R9", "waits after address", n_log - n0, 1);
    sw_send(2'd0);
    chk(n_log - n0 == 2 && log_cmd[n0 + 1] == 3'd1 &&
        int'(log_dat[n0 + 1]) == ((8'h30 + t0) & 255), "R9", "manual write",
        log_dat[n0 + 1], (8'h30 + t0) & 255);
    chk(!len_err && busy, "R9", "no auto stop or length error on nack",
        {len_err, busy}, 1);
    sw_send(2'd2);
    chk(n_log - n0 == 3 && log_cmd[n0 + 2] == 3'd3 && rx_n - r0 == 1, "R9",
        "manual read nack", log_cmd[n0 + 2], 3);
    chk(int'(rx_log[r0]) == ((8'h5A + n0 + 2) & 255), "R4", "manual read byte",
        rx_log[r0], (8'h5A + n0 + 2) & 255);
    sw_send(2'd1);
    chk(n_log - n0 == 4 && log_cmd[n0 + 3] == 3'd2, "R9", "manual read ack",
        log_cmd[n0 + 3], 2);
    sw_send(2'd3);
    chk(n_log - n0 == 5 && log_cmd[n0 + 4] == 3'd4 && !busy, "R9",
        "manual stop", log_cmd[n0 + 4], 4);

    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tot++;
      $display("FAIL R10 watchdog: act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_tot);
      $finish;
    end
  end
endmodule